// File: doc/BRIEF.md
# JTAG Debug Port with Posted Reads

This block is the target-side end of a JTAG debug link. A TAP controller with a 4-bit instruction register selects one of four data chains: a 32-bit identification chain, a 1-bit bypass chain, and two 35-bit access chains. One access chain reaches the port's own registers. The other forwards transactions to a downstream access port over a simple request/response bus. The port's own registers are a control/status word, a select word and a read buffer.

Reads are posted. A read scan only launches the access. Its data is captured into the next access scan, so a debugger usually ends a read burst by reading the read buffer, which has no side effects. A failed downstream response sets a sticky error that stays set until a one is written to it. Two power-up requests are each acknowledged after a fixed delay.

A TCK counter raises a debugger-connected flag once enough clocks have followed a TAP reset. Only the reset pin clears this flag.

Top module: `jtag_dbg_port`

## Requirements
- R1: After rst_ni is released the instruction register holds 0xE, and a 32-bit DR scan shifts out 0x4BA00477 LSB first. Loading 0xE selects the same chain.
- R2: The instruction register is 4 bits. Capture-IR loads 4'b0001, and its LSB is shifted out first.
- R3: Instruction 0xF selects a 1-bit bypass chain that captures 0. So does any code other than 0xA, 0xB and 0xE. Data shifted through it appears at tdo_o one TCK later.
- R4: An access scan is 35 bits, LSB first. Bit 0 is read-not-write (1 = read), bits 2:1 are the register address and bits 34:3 are write data. On the way out, bits 34:3 carry the pending result and bits 2:0 are 0. The pending result is 0 after reset.
- R5: A read scan does not return its own data; that data is captured by the following access scan. A read of port address 3 (instruction 0xA) returns the pending result and leaves it unchanged, so repeated reads of address 3 return the same value.
- R6: Port address 2 is the select word. Bits 31:24 drive ap_sel_o and bits 7:4 drive ap_bank_o. Reading it back returns those fields with all other bits 0. Address 0 reads as 0.
- R7: An access-port scan (instruction 0xB) raises ap_req_o at its Update-DR edge. It presents ap_write_o = not bit 0, ap_addr_o = bits 2:1 and ap_wdata_o = bits 34:3. The request is held stable until the edge at which ap_rsp_valid_i is high. Read response data becomes the pending result.
- R8: In the control/status word (address 1), bits 28 and 30 are power-up requests that are written and read back. Bits 29 and 31 are their acknowledges. Each acknowledge follows its request 4 TCK cycles later.
- R9: Bit 5 of the control/status word is a sticky error. A response with ap_rsp_err_i high sets it. Writing 1 to bit 5 clears it. Writing 0 leaves it unchanged.
- R10: dbg_connected_o rises on the 16th TCK rising edge after rst_ni is released. A TMS-driven Test-Logic-Reset does not clear it; only rst_ni does.
- R11: TMS held high keeps the TAP in Test-Logic-Reset. Five TMS-high clocks from any state reach that state and reload 0xE into the instruction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock, clocks all state |
| rst_ni | input | 1 | Active-low asynchronous TAP reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, valid in Shift-IR/Shift-DR |
| dbg_connected_o | output | 1 | Debugger-connected flag |
| ap_req_o | output | 1 | Downstream request pending |
| ap_write_o | output | 1 | Request is a write |
| ap_addr_o | output | 2 | Access-port register address |
| ap_sel_o | output | 8 | Selected access port |
| ap_bank_o | output | 4 | Selected register bank |
| ap_wdata_o | output | 32 | Write data |
| ap_rsp_valid_i | input | 1 | Response strobe, completes the request |
| ap_rsp_err_i | input | 1 | Response is an error |
| ap_rdata_i | input | 32 | Read response data |

## Verification
Several rules are checked on every cycle by assertions. Test-Logic-Reset holds under TMS high, and the connected flag never falls outside reset. A pending downstream request stays frozen until its response. An error response always leaves the sticky bit set, and the sticky bit survives any cycle without a write of one. The bench scenarios are needed for the rest: posted-read ordering across scans, the side-effect-free read buffer, select and control readback, IR capture and bypass latency, and the exact TCK count at which the connected flag rises.

// File: rtl/jdp_pkg.sv
package jdp_pkg;
  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {CH_BYP, CH_ID, CH_DP, CH_AP} chain_e;

  localparam int          IR_W      = 4;
  localparam logic [3:0]  IR_DPACC  = 4'hA;
  localparam logic [3:0]  IR_APACC  = 4'hB;
  localparam logic [3:0]  IR_IDCODE = 4'hE;
  localparam logic [3:0]  IR_CAPT   = 4'b0001;

  localparam int          DATA_W    = 32;
  localparam int          HDR_W     = 3;
  localparam int          ACC_W     = DATA_W + HDR_W;

  localparam logic [1:0]  DP_CTRL   = 2'd1;
  localparam logic [1:0]  DP_SEL    = 2'd2;
  localparam logic [1:0]  DP_RBUF   = 2'd3;

  localparam int          ERR_BIT   = 5;
  localparam int          PREQ_LSB  = 28;  // req at 28+2g, ack at 29+2g
  localparam int          SEL_LSB   = 24;
  localparam int          BANK_LSB  = 4;
endpackage

// File: rtl/jdp_tap.sv
module jdp_tap
  import jdp_pkg::*;
(
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tms_i,
  input  logic             tdi_i,
  output tap_state_e       state_o,
  output logic [IR_W-1:0]  ir_o,
  output logic             ir_tdo_o
);
  tap_state_e state_q, state_d;
  logic [IR_W-1:0] ir_sr_q, ir_q;

  always_comb begin
    unique case (state_q)
      TLR:     state_d = tms_i ? TLR    : RTI;
      RTI:     state_d = tms_i ? SEL_DR : RTI;
      SEL_DR:  state_d = tms_i ? SEL_IR : CAP_DR;
      CAP_DR:  state_d = tms_i ? EX1_DR : SH_DR;
      SH_DR:   state_d = tms_i ? EX1_DR : SH_DR;
      EX1_DR:  state_d = tms_i ? UPD_DR : PAU_DR;
      PAU_DR:  state_d = tms_i ? EX2_DR : PAU_DR;
      EX2_DR:  state_d = tms_i ? UPD_DR : SH_DR;
      UPD_DR:  state_d = tms_i ? SEL_DR : RTI;
      SEL_IR:  state_d = tms_i ? TLR    : CAP_IR;
      CAP_IR:  state_d = tms_i ? EX1_IR : SH_IR;
      SH_IR:   state_d = tms_i ? EX1_IR : SH_IR;
      EX1_IR:  state_d = tms_i ? UPD_IR : PAU_IR;
      PAU_IR:  state_d = tms_i ? EX2_IR : PAU_IR;
      EX2_IR:  state_d = tms_i ? UPD_IR : SH_IR;
      UPD_IR:  state_d = tms_i ? SEL_DR : RTI;
      default: state_d = TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TLR;
      ir_sr_q <= IR_CAPT;
      ir_q    <= IR_IDCODE;
    end else begin
      state_q <= state_d;
      if (state_q == CAP_IR)      ir_sr_q <= IR_CAPT;
      else if (state_q == SH_IR)  ir_sr_q <= {tdi_i, ir_sr_q[IR_W-1:1]};
      if (state_q == TLR)         ir_q <= IR_IDCODE;
      else if (state_q == UPD_IR) ir_q <= ir_sr_q;
    end
  end

  assign state_o  = state_q;
  assign ir_o     = ir_q;
  assign ir_tdo_o = ir_sr_q[0];

  // R11
  tlr_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == TLR && tms_i) |=> (state_q == TLR));
  // R11
  tlr_ir_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == TLR) |=> (ir_q == IR_IDCODE));
endmodule

// File: rtl/jdp_conn_det.sv
module jdp_conn_det #(
  parameter int CntMax = 16
) (
  input  logic tck_i,
  input  logic rst_ni,
  output logic connected_o
);
  localparam int CntW = $clog2(CntMax + 1);
  localparam logic [CntW-1:0] CntTop = CntW'(CntMax);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q != CntTop) cnt_q <= cnt_q + 1'b1;
  end

  assign connected_o = (cnt_q == CntTop);

  // R10
  conn_sticky_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    connected_o |=> connected_o);
endmodule

// File: rtl/jdp_port_regs.sv
module jdp_port_regs
  import jdp_pkg::*;
#(
  parameter int AckDly = 4,
  parameter int SelW   = 8,
  parameter int BankW  = 4
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              ap_i,
  input  logic              rnw_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] result_o,
  output logic              req_o,
  output logic              req_write_o,
  output logic [1:0]        req_addr_o,
  output logic [SelW-1:0]   sel_o,
  output logic [BankW-1:0]  bank_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  input  logic [DATA_W-1:0] rsp_rdata_i
);
  localparam int NPwr = 2;

  logic [NPwr-1:0]   pwr_req_q, pwr_ack;
  logic              sticky_q;
  logic [SelW-1:0]   sel_q;
  logic [BankW-1:0]  bank_q;
  logic [DATA_W-1:0] result_q, ctrl_rd, sel_rd;
  logic              req_q, req_we_q;
  logic [1:0]        req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;

  wire dp_wr    = upd_i && !ap_i && !rnw_i;
  wire dp_rd    = upd_i && !ap_i &&  rnw_i;
  wire ap_upd   = upd_i &&  ap_i;
  wire rsp_fire = req_q && rsp_valid_i;
  wire err_clr  = dp_wr && (addr_i == DP_CTRL) && wdata_i[ERR_BIT];

  for (genvar g = 0; g < NPwr; g++) begin : g_pwr
    logic [AckDly-1:0] dly_q;
    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni) dly_q <= '0;
      else         dly_q <= (dly_q << 1) | AckDly'(pwr_req_q[g]);
    end
    assign pwr_ack[g] = dly_q[AckDly-1];
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[ERR_BIT] = sticky_q;
    for (int i = 0; i < NPwr; i++) begin
      ctrl_rd[PREQ_LSB + 2*i]     = pwr_req_q[i];
      ctrl_rd[PREQ_LSB + 2*i + 1] = pwr_ack[i];
    end
    sel_rd = '0;
    sel_rd[SEL_LSB +: SelW]   = sel_q;
    sel_rd[BANK_LSB +: BankW] = bank_q;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_req_q   <= '0;
      sticky_q    <= 1'b0;
      sel_q       <= '0;
      bank_q      <= '0;
      result_q    <= '0;
      req_q       <= 1'b0;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
    end else begin
      if (dp_wr && addr_i == DP_CTRL) begin
        for (int i = 0; i < NPwr; i++) pwr_req_q[i] <= wdata_i[PREQ_LSB + 2*i];
      end
      if (dp_wr && addr_i == DP_SEL) begin
        sel_q  <= wdata_i[SEL_LSB +: SelW];
        bank_q <= wdata_i[BANK_LSB +: BankW];
      end
      // set wins over a same-cycle clear
      if (rsp_fire && rsp_err_i) sticky_q <= 1'b1;
      else if (err_clr)          sticky_q <= 1'b0;
      // read buffer keeps the pending result
      if (dp_rd && addr_i != DP_RBUF) begin
        unique case (addr_i)
          DP_CTRL: result_q <= ctrl_rd;
          DP_SEL:  result_q <= sel_rd;
          default: result_q <= '0;
        endcase
      end else if (rsp_fire && !req_we_q) begin
        result_q <= rsp_rdata_i;
      end
      // a new access while one is outstanding is dropped
      if (ap_upd && !req_q) begin
        req_q       <= 1'b1;
        req_we_q    <= !rnw_i;
        req_addr_q  <= addr_i;
        req_wdata_q <= wdata_i;
      end else if (rsp_fire) begin
        req_q <= 1'b0;
      end
    end
  end

  assign result_o    = result_q;
  assign req_o       = req_q;
  assign req_write_o = req_we_q;
  assign req_addr_o  = req_addr_q;
  assign req_wdata_o = req_wdata_q;
  assign sel_o       = sel_q;
  assign bank_o      = bank_q;

  // R7
  req_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (req_o && !rsp_valid_i) |=> (req_o && $stable(req_addr_o) &&
                                 $stable(req_wdata_o) && $stable(req_write_o)));
  // R9
  sticky_set_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (req_o && rsp_valid_i && rsp_err_i) |=> sticky_q);
  // R9
  sticky_keep_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sticky_q && !err_clr) |=> sticky_q);
endmodule

// File: rtl/jtag_dbg_port.sv
module jtag_dbg_port
  import jdp_pkg::*;
#(
  parameter logic [31:0] IdCode     = 32'h4BA00477,
  parameter int          ConnCycles = 16,
  parameter int          AckDelay   = 4,
  parameter int          SelW       = 8,
  parameter int          BankW      = 4
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              dbg_connected_o,
  output logic              ap_req_o,
  output logic              ap_write_o,
  output logic [1:0]        ap_addr_o,
  output logic [SelW-1:0]   ap_sel_o,
  output logic [BankW-1:0]  ap_bank_o,
  output logic [DATA_W-1:0] ap_wdata_o,
  input  logic              ap_rsp_valid_i,
  input  logic              ap_rsp_err_i,
  input  logic [DATA_W-1:0] ap_rdata_i
);
  tap_state_e        state;
  logic [IR_W-1:0]   ir;
  logic              ir_tdo;
  chain_e            chain;
  logic [ACC_W-1:0]  dr_sr_q;
  logic [DATA_W-1:0] result;
  logic              acc_upd;

  jdp_tap u_tap (
    .tck_i, .rst_ni, .tms_i, .tdi_i,
    .state_o (state),
    .ir_o    (ir),
    .ir_tdo_o(ir_tdo)
  );

  jdp_conn_det #(.CntMax(ConnCycles)) u_conn (
    .tck_i, .rst_ni,
    .connected_o(dbg_connected_o)
  );

  always_comb begin
    unique case (ir)
      IR_DPACC:  chain = CH_DP;
      IR_APACC:  chain = CH_AP;
      IR_IDCODE: chain = CH_ID;
      default:   chain = CH_BYP;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_sr_q <= '0;
    end else if (state == CAP_DR) begin
      unique case (chain)
        CH_ID:        dr_sr_q <= {{HDR_W{1'b0}}, IdCode};
        CH_DP, CH_AP: dr_sr_q <= {result, {HDR_W{1'b0}}};
        default:      dr_sr_q <= '0;
      endcase
    end else if (state == SH_DR) begin
      unique case (chain)
        CH_ID:        dr_sr_q <= {{HDR_W{1'b0}}, tdi_i, dr_sr_q[DATA_W-1:1]};
        CH_DP, CH_AP: dr_sr_q <= {tdi_i, dr_sr_q[ACC_W-1:1]};
        default:      dr_sr_q <= {{(ACC_W-1){1'b0}}, tdi_i};
      endcase
    end
  end

  assign acc_upd = (state == UPD_DR) && (chain == CH_DP || chain == CH_AP);

  jdp_port_regs #(.AckDly(AckDelay), .SelW(SelW), .BankW(BankW)) u_regs (
    .tck_i, .rst_ni,
    .upd_i      (acc_upd),
    .ap_i       (chain == CH_AP),
    .rnw_i      (dr_sr_q[0]),
    .addr_i     (dr_sr_q[2:1]),
    .wdata_i    (dr_sr_q[ACC_W-1:HDR_W]),
    .result_o   (result),
    .req_o      (ap_req_o),
    .req_write_o(ap_write_o),
    .req_addr_o (ap_addr_o),
    .sel_o      (ap_sel_o),
    .bank_o     (ap_bank_o),
    .req_wdata_o(ap_wdata_o),
    .rsp_valid_i(ap_rsp_valid_i),
    .rsp_err_i  (ap_rsp_err_i),
    .rsp_rdata_i(ap_rdata_i)
  );

  always_comb begin
    if (state == SH_IR)      tdo_o = ir_tdo;
    else if (state == SH_DR) tdo_o = dr_sr_q[0];
    else                     tdo_o = 1'b0;
  end

  // R4
  dr_idle_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state != CAP_DR && state != SH_DR) |=> $stable(dr_sr_q));
endmodule

// File: tb/jtag_dbg_port_tb.sv
module jtag_dbg_port_tb;
  logic        tck = 1'b0;
  logic        rst_ni, tms_i, tdi_i, tdo_o, dbg_connected_o;
  logic        ap_req_o, ap_write_o, ap_rsp_valid_i, ap_rsp_err_i;
  logic [1:0]  ap_addr_o;
  logic [7:0]  ap_sel_o;
  logic [3:0]  ap_bank_o;
  logic [31:0] ap_wdata_o, ap_rdata_i;

  always #4 tck = ~tck;

  jtag_dbg_port u_dut (
    .tck_i(tck), .rst_ni, .tms_i, .tdi_i, .tdo_o, .dbg_connected_o,
    .ap_req_o, .ap_write_o, .ap_addr_o, .ap_sel_o, .ap_bank_o, .ap_wdata_o,
    .ap_rsp_valid_i, .ap_rsp_err_i, .ap_rdata_i
  );

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { string tag; logic [31:0] val; } exp_t;
  exp_t exp_q[$];

  logic [31:0] ap_mem [64];
  logic        rec_write;
  logic [1:0]  rec_addr;
  logic [31:0] rec_wdata;

  logic [3:0]  cur_ir;
  logic        m_req0, m_req1, m_sticky;
  logic [7:0]  m_sel;
  logic [3:0]  m_bank;
  logic [31:0] m_res;

  task automatic chk(string tag, logic [34:0] act, logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // downstream responder: 2-cycle latency, select 0xFF answers with error
  initial begin
    int dly;
    dly = 2;
    ap_rsp_valid_i = 0; ap_rsp_err_i = 0; ap_rdata_i = '0;
    for (int i = 0; i < 64; i++) ap_mem[i] = 32'h1000_0000 + i * 32'h0101_0101;
    forever begin
      @(negedge tck);
      if (ap_rsp_valid_i) begin
        ap_rsp_valid_i = 0; ap_rsp_err_i = 0;
      end else if (ap_req_o) begin
        if (dly == 0) begin
          ap_rsp_valid_i = 1;
          rec_write = ap_write_o; rec_addr = ap_addr_o; rec_wdata = ap_wdata_o;
          if (ap_sel_o == 8'hFF) begin
            ap_rsp_err_i = 1; ap_rdata_i = 32'hBAD0_0000;
          end else begin
            ap_rsp_err_i = 0;
            if (ap_write_o) ap_mem[{ap_bank_o, ap_addr_o}] = ap_wdata_o;
            else            ap_rdata_i = ap_mem[{ap_bank_o, ap_addr_o}];
          end
        end else dly--;
      end else dly = 2;
    end
  end

  task automatic tick(input logic tms, input logic tdi, output logic tdo_s);
    @(negedge tck);
    tms_i = tms; tdi_i = tdi; tdo_s = tdo_o;
  endtask

  task automatic ir_scan(input logic [3:0] ir, output logic [3:0] cap);
    logic t;
    tick(1, 0, t); tick(1, 0, t); tick(0, 0, t); tick(0, 0, t);
    for (int i = 0; i < 4; i++) tick(i == 3, ir[i], cap[i]);
    tick(1, 0, t); tick(0, 0, t);
    cur_ir = ir;
  endtask

  task automatic dr_scan(input int n, input logic [34:0] din, output logic [34:0] dout);
    logic t;
    dout = '0;
    tick(1, 0, t); tick(0, 0, t); tick(0, 0, t);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i], dout[i]);
    tick(1, 0, t); tick(0, 0, t);
    for (int i = 0; i < 6; i++) tick(0, 0, t);
  endtask

  function automatic logic [31:0] ctrl_m();
    return {m_req1, m_req1, m_req0, m_req0, 22'b0, m_sticky, 5'b0};
  endfunction

  // driver: one access scan; monitor compares the capture against the queue
  task automatic acc(input bit ap, input bit rnw, input logic [1:0] addr,
                     input logic [31:0] wd, input string tag);
    logic [34:0] dout;
    logic [3:0]  c;
    exp_t e;
    if (ap && cur_ir != 4'hB)  ir_scan(4'hB, c);
    if (!ap && cur_ir != 4'hA) ir_scan(4'hA, c);
    dr_scan(35, {wd, addr, rnw}, dout);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(e.tag, {3'b0, dout[34:3]}, {3'b0, e.val});
    end
    chk("R4 ack bits", {32'b0, dout[2:0]}, 35'd0);
    if (rnw) begin
      if (ap) begin
        if (m_sel == 8'hFF) begin m_res = 32'hBAD0_0000; m_sticky = 1; end
        else m_res = ap_mem[{m_bank, addr}];
      end else begin
        case (addr)
          2'd0: m_res = 32'h0;
          2'd1: m_res = ctrl_m();
          2'd2: m_res = {m_sel, 16'h0, m_bank, 4'h0};
          default: ;
        endcase
      end
    end else begin
      if (ap) begin
        if (m_sel == 8'hFF) m_sticky = 1;
      end else if (addr == 2'd1) begin
        m_req0 = wd[28]; m_req1 = wd[30];
        if (wd[5]) m_sticky = 0;
      end else if (addr == 2'd2) begin
        m_sel = wd[31:24]; m_bank = wd[7:4];
      end
    end
    exp_q.push_back('{tag, m_res});
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [34:0] d;
    logic [3:0]  c;
    logic        t;
    m_req0 = 0; m_req1 = 0; m_sticky = 0; m_sel = 0; m_bank = 0; m_res = 0;
    exp_q.push_back('{"R4 reset result", 32'h0});
    rst_ni = 0; tms_i = 1; tdi_i = 0; cur_ir = 4'hE;
    repeat (3) @(negedge tck);
    chk("R10 reset flag", {34'b0, dbg_connected_o}, 35'd0);
    rst_ni = 1;
    repeat (15) @(posedge tck);
    @(negedge tck);
    chk("R10 after 15 TCK", {34'b0, dbg_connected_o}, 35'd0);
    @(posedge tck);
    @(negedge tck);
    chk("R10 after 16 TCK", {34'b0, dbg_connected_o}, 35'd1);

    tick(0, 0, t);
    dr_scan(32, '0, d);
    chk("R1 reset IDCODE", d, {3'b0, 32'h4BA00477});
    ir_scan(4'hE, c);
    chk("R2 IR capture", {31'b0, c}, 35'd1);
    dr_scan(32, '0, d);
    chk("R1 IDCODE instr", d, {3'b0, 32'h4BA00477});

    ir_scan(4'hF, c);
    dr_scan(8, 35'hB3, d);
    chk("R3 bypass", d, 35'h66);
    ir_scan(4'h5, c);
    dr_scan(8, 35'h5A, d);
    chk("R3 unknown code", d, 35'hB4);

    acc(0, 0, 2'd2, 32'h0300_0050, "R6");
    chk("R6 sel port", {27'b0, ap_sel_o}, 35'h3);
    chk("R6 bank port", {31'b0, ap_bank_o}, 35'h5);
    acc(0, 1, 2'd2, 0, "R6 sel readback");
    acc(0, 1, 2'd0, 0, "R6 addr0 zero");
    acc(0, 0, 2'd2, 32'h0000_0000, "R6");

    acc(1, 0, 2'd1, 32'hA5A5_1234, "R7");
    chk("R7 write addr", {33'b0, rec_addr}, 35'd1);
    chk("R7 write data", {3'b0, rec_wdata}, {3'b0, 32'hA5A5_1234});
    chk("R7 write dir", {34'b0, rec_write}, 35'd1);
    acc(1, 0, 2'd2, 32'h0BAD_F00D, "R7");
    acc(1, 1, 2'd1, 0, "R5 posted AP read");
    chk("R7 read dir", {34'b0, rec_write}, 35'd0);
    acc(1, 1, 2'd2, 0, "R5 back-to-back read");
    acc(0, 1, 2'd3, 0, "R5 read buffer");
    acc(0, 1, 2'd3, 0, "R5 read buffer repeat");
    acc(0, 1, 2'd3, 0, "R5 read buffer repeat");

    acc(0, 0, 2'd1, 32'h5000_0000, "R8");
    acc(0, 1, 2'd1, 0, "R8 both requests");
    acc(0, 0, 2'd1, 32'h1000_0000, "R8");
    acc(0, 1, 2'd1, 0, "R8 one request");

    acc(0, 0, 2'd2, 32'hFF00_0000, "R9");
    acc(1, 1, 2'd0, 0, "R9 error read data");
    acc(0, 1, 2'd1, 0, "R9 sticky set");
    acc(0, 0, 2'd1, 32'h1000_0000, "R9");
    acc(0, 1, 2'd1, 0, "R9 write 0 keeps");
    acc(0, 0, 2'd1, 32'h1000_0020, "R9");
    acc(0, 1, 2'd1, 0, "R9 write 1 clears");
    acc(0, 1, 2'd3, 0, "R9 final");

    for (int i = 0; i < 5; i++) tick(1, 0, t);
    tick(1, 0, t);
    chk("R10 kept after TLR", {34'b0, dbg_connected_o}, 35'd1);
    tick(0, 0, t);
    dr_scan(32, '0, d);
    chk("R11 TLR reloads IDCODE", d, {3'b0, 32'h4BA00477});

    @(negedge tck);
    rst_ni = 0;
    #1;
    chk("R10 cleared by rst_ni", {34'b0, dbg_connected_o}, 35'd0);
    @(negedge tck);
    rst_ni = 1;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule